// File: doc/BRIEF.md
# Multi-mode quadrature encoder counter

This block counts position or time. Its count source is either the two encoder lines A and B, or the block's own clock. Three encoder modes are available. In the first, edges on A are counted and the level of B sets the direction. In the second, edges on B are counted and the level of A sets the direction. In the third, both lines are decoded as a quadrature pair, so each count step is a quarter of a full encoder cycle. Two clock-driven modes count once per enabled cycle. One of them also reloads the counter on the rising edge of an on-chip trigger.

The counting range is bounded by a preset. Counting up wraps from the preset to zero, and counting down wraps from zero to the preset. Each wrap produces a one-cycle limit event. The preset can be double-buffered, so that a new limit takes effect only at the next wrap.

A simple register port gives the host access to the count, the preset, a control word and the mode. A write takes effect on the clock edge at which `wr_en` is high. A read returns data combinationally for `rd_addr`. No data stream crosses the block's edge, so all pins are plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, the preset reads all ones, the control word and mode read 0, and the limit event is low.
- R2: Register addresses are: 0 count (read/write, a write loads the count), 1 preset, 2 control, 3 mode (bits 2:0). Control bits are: bit 0 enable, bit 4 direction (1 = down), bit 7 preload enable, bit 8 sticky quadrature error (read-only; writing 1 clears it). A host write to the count overrides any step in the same cycle.
- R3: In mode 0 and mode 4, while enabled, the count moves by one every clock in the direction of control bit 4.
- R4: Counting up from a count equal to the active preset gives 0 and raises the limit event for exactly one cycle.
- R5: Counting down from 0 gives the active preset and raises the limit event for exactly one cycle.
- R6: Writing the preset sets control bit 7. If bit 7 was already set, the new value becomes active only at the next wrap; otherwise it is active at once. Reading the preset returns the last value written.
- R7: In mode 1 every edge of A (rising or falling) is one step, up while B is low and down while B is high. Edges of B alone do not count.
- R8: In mode 2 every edge of B is one step, up while A is low and down while A is high. Edges of A alone do not count.
- R9: In mode 3 the {A,B} sequence 00→10→11→01→00 counts up by one per transition, and the reverse sequence counts down.
- R10: In mode 3, a sample in which A and B both change gives no step and sets the sticky error bit, which holds until the host clears it.
- R11: In modes 1 to 3 the direction bit cannot be written by the host and shows the direction of the last step.
- R12: In mode 4, a rising edge of `trig_in` reloads the count: to 0 when counting up, or to the active preset when counting down. A host count write in the same cycle takes priority.
- R13: While control bit 0 is clear, no mode changes the count except by a host write or a trigger reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder line A (asynchronous) |
| enc_b | input | 1 | Encoder line B (asynchronous) |
| trig_in | input | 1 | On-chip reload trigger, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | Current direction, 1 = down |
| limit_evt_o | output | 1 | One-cycle wrap event |
| qerr_o | output | 1 | Sticky quadrature error |

## Verification
The assertions check, on every cycle:
- that a wrap in either direction lands on the right value and pulses the event;
- that a disabled counter holds its count;
- that the error bit stays set until cleared;
- that an invalid quadrature sample never produces a step;
- that the host cannot move the direction bit in encoder modes.

Only the directed scenarios can show the end-to-end effects:
- that each mode counts the right edges through the synchronizer;
- that a buffered preset waits for the wrap before it applies;
- that a trigger reload picks its value from the direction and loses to a host write.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [2:0] {
    MODE_CLK  = 3'd0,
    MODE_ENCA = 3'd1,
    MODE_ENCB = 3'd2,
    MODE_QUAD = 3'd3,
    MODE_TRIG = 3'd4
  } mode_e;

  localparam logic [1:0] REG_COUNT  = 2'd0;
  localparam logic [1:0] REG_PRESET = 2'd1;
  localparam logic [1:0] REG_CTRL   = 2'd2;
  localparam logic [1:0] REG_MODE   = 2'd3;

  localparam int BIT_EN  = 0;
  localparam int BIT_DIR = 4;
  localparam int BIT_PRE = 7;
  localparam int BIT_ERR = 8;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_in,
  input  logic b_in,
  output logic a_lvl,
  output logic b_lvl,
  output logic a_edge,
  output logic b_edge
);
  logic [STAGES-1:0] a_sh, b_sh;
  logic a_prev, b_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh   <= '0;
      b_sh   <= '0;
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_sh[0] <= a_in;
      b_sh[0] <= b_in;
      for (int i = 1; i < STAGES; i++) begin
        a_sh[i] <= a_sh[i-1];
        b_sh[i] <= b_sh[i-1];
      end
      a_prev <= a_sh[STAGES-1];
      b_prev <= b_sh[STAGES-1];
    end
  end

  assign a_lvl  = a_sh[STAGES-1];
  assign b_lvl  = b_sh[STAGES-1];
  assign a_edge = a_lvl ^ a_prev;
  assign b_edge = b_lvl ^ b_prev;
endmodule

// File: rtl/qenc_stepgen.sv
module qenc_stepgen
  import qenc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  en,
  input  logic  host_dir,
  input  logic  a_lvl,
  input  logic  b_lvl,
  input  logic  a_edge,
  input  logic  b_edge,
  output logic  step,
  output logic  step_down,
  output logic  bad_trans,
  output logic  is_enc
);
  always_comb begin
    step      = 1'b0;
    step_down = host_dir;
    bad_trans = 1'b0;
    is_enc    = 1'b0;
    unique case (mode)
      MODE_CLK, MODE_TRIG: begin
        step = en;
      end
      MODE_ENCA: begin
        is_enc    = 1'b1;
        step      = en & a_edge;
        step_down = b_lvl;
      end
      MODE_ENCB: begin
        is_enc    = 1'b1;
        step      = en & b_edge;
        step_down = a_lvl;
      end
      MODE_QUAD: begin
        is_enc    = 1'b1;
        bad_trans = en & a_edge & b_edge;
        step      = en & (a_edge ^ b_edge);
        // A moving with A!=B afterwards, or B moving with A==B, is forward
        step_down = a_edge ? (a_lvl == b_lvl) : (a_lvl != b_lvl);
      end
      default: begin
        step = 1'b0;
      end
    endcase
  end

  p_quad_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_QUAD && a_edge && b_edge) |-> !step);
endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             step_down,
  input  logic             cnt_wr,
  input  logic             pre_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             preload_en,
  input  logic             reload,
  input  logic             reload_down,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] preset_shadow,
  output logic             evt
);
  logic [CNT_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      act_q         <= '1;
      preset_shadow <= '1;
      evt           <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (cnt_wr) begin
        cnt <= wdata;
      end else if (reload) begin
        cnt <= reload_down ? act_q : '0;
      end else if (step) begin
        if (!step_down) begin
          if (cnt == act_q) begin
            cnt   <= '0;
            evt   <= 1'b1;
            act_q <= preset_shadow;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          if (cnt == '0) begin
            cnt   <= act_q;
            evt   <= 1'b1;
            act_q <= preset_shadow;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
      if (pre_wr) begin
        preset_shadow <= wdata;
        if (!preload_en) act_q <= wdata;
      end
    end
  end

  p_up_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_down && cnt == act_q && !cnt_wr && !reload) |=> (evt && cnt == '0));

  p_down_wrap_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_down && cnt == '0 && !cnt_wr && !reload) |=> (evt && cnt == $past(act_q)));

  p_evt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !step && !reload) |=> !evt);
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             trig_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             limit_evt_o,
  output logic             qerr_o
);
  mode_e mode_q;
  logic  en_q, dir_q, pre_q, err_q, trig_q;
  logic  a_lvl, b_lvl, a_edge, b_edge;
  logic  step, step_down, bad_trans, is_enc;
  logic  cnt_wr, pre_wr, ctrl_wr, mode_wr, reload;
  logic [CNT_W-1:0] preset_shadow;

  assign cnt_wr  = wr_en && wr_addr == REG_COUNT;
  assign pre_wr  = wr_en && wr_addr == REG_PRESET;
  assign ctrl_wr = wr_en && wr_addr == REG_CTRL;
  assign mode_wr = wr_en && wr_addr == REG_MODE;
  assign reload  = (mode_q == MODE_TRIG) && trig_in && !trig_q;

  qenc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .a_in(enc_a), .b_in(enc_b),
    .a_lvl(a_lvl), .b_lvl(b_lvl), .a_edge(a_edge), .b_edge(b_edge)
  );

  qenc_stepgen u_step (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .en(en_q), .host_dir(dir_q),
    .a_lvl(a_lvl), .b_lvl(b_lvl), .a_edge(a_edge), .b_edge(b_edge),
    .step(step), .step_down(step_down), .bad_trans(bad_trans), .is_enc(is_enc)
  );

  qenc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .step_down(step_down),
    .cnt_wr(cnt_wr), .pre_wr(pre_wr), .wdata(wr_data), .preload_en(pre_q),
    .reload(reload), .reload_down(dir_q), .cnt(count_o),
    .preset_shadow(preset_shadow), .evt(limit_evt_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CLK;
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      pre_q  <= 1'b0;
      err_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_in;
      if (mode_wr) mode_q <= mode_e'(wr_data[2:0]);
      if (pre_wr)  pre_q  <= 1'b1;
      if (ctrl_wr) begin
        en_q  <= wr_data[BIT_EN];
        pre_q <= wr_data[BIT_PRE];
        if (!is_enc) dir_q <= wr_data[BIT_DIR];
        if (wr_data[BIT_ERR]) err_q <= 1'b0;
      end
      if (is_enc && step) dir_q <= step_down;
      if (bad_trans) err_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      REG_COUNT:  rd_data = count_o;
      REG_PRESET: rd_data = preset_shadow;
      REG_CTRL: begin
        rd_data[BIT_EN]  = en_q;
        rd_data[BIT_DIR] = dir_q;
        rd_data[BIT_PRE] = pre_q;
        rd_data[BIT_ERR] = err_q;
      end
      default: rd_data[2:0] = mode_q;
    endcase
  end

  assign dir_o  = dir_q;
  assign qerr_o = err_q;

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(ctrl_wr && wr_data[BIT_ERR])) |=> err_q);

  p_dir_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_enc && !step) |=> $stable(dir_q));

  p_hold_when_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_wr && !reload) |=> $stable(count_o));
endmodule

// File: tb/sim_qenc_counter.sv
module sim_qenc_counter;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, trig_in = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data, count_o;
  logic dir_o, limit_evt_o, qerr_o;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  qenc_counter #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .trig_in(trig_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .count_o(count_o), .dir_o(dir_o),
    .limit_evt_o(limit_evt_o), .qerr_o(qerr_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 count", int'(count_o), 0);
    chk("R1 event", int'(limit_evt_o), 0);
    rd(2'd1, v); chk("R1 preset", v, 16'hFFFF);
    rd(2'd2, v); chk("R1 ctrl", v, 0);
    rd(2'd3, v); chk("R1 mode", v, 0);
  endtask

  task automatic t_clk_up();
    wr(2'd3, 0);
    wr(2'd0, 10);
    chk("R2 count load", int'(count_o), 10);
    wr(2'd1, 12);
    wr(2'd2, 'h81);
    chk("R3 start", int'(count_o), 10);
    @(negedge clk); chk("R3 up step", int'(count_o), 11);
    @(negedge clk); chk("R3 at preset", int'(count_o), 12);
    @(negedge clk); chk("R4 wrap to zero", int'(count_o), 0);
    chk("R4 event high", int'(limit_evt_o), 1);
    @(negedge clk); chk("R4 after wrap", int'(count_o), 1);
    chk("R4 event one cycle", int'(limit_evt_o), 0);
  endtask

  task automatic t_clk_down();
    wr(2'd2, 'h80);
    wr(2'd0, 1);
    wr(2'd2, 'h91);
    @(negedge clk); chk("R3 down step", int'(count_o), 0);
    @(negedge clk); chk("R5 wrap to preset", int'(count_o), 12);
    chk("R5 event high", int'(limit_evt_o), 1);
    @(negedge clk); chk("R5 event one cycle", int'(limit_evt_o), 0);
  endtask

  task automatic t_preload();
    int v;
    wr(2'd2, 'h80);
    wr(2'd1, 5);
    rd(2'd1, v); chk("R6 preset readback", v, 5);
    rd(2'd2, v); chk("R6 preload bit", (v >> 7) & 1, 1);
    wr(2'd0, 11);
    wr(2'd2, 'h81);
    @(negedge clk); chk("R6 old limit kept", int'(count_o), 12);
    @(negedge clk); chk("R6 wrap at old limit", int'(count_o), 0);
    repeat (5) @(negedge clk);
    chk("R6 new limit reached", int'(count_o), 5);
    @(negedge clk); chk("R6 wrap at new limit", int'(count_o), 0);
    chk("R6 event at new limit", int'(limit_evt_o), 1);
  endtask

  task automatic t_enable();
    wr(2'd2, 0);
    wr(2'd0, 3);
    repeat (5) @(negedge clk);
    chk("R13 disabled hold", int'(count_o), 3);
    wr(2'd1, 1000);
  endtask

  task automatic t_mode_a();
    int v;
    wr(2'd3, 1);
    wr(2'd0, 100);
    wr(2'd2, 'h11);
    rd(2'd2, v); chk("R11 dir write ignored", (v >> 4) & 1, 0);
    for (int i = 0; i < 3; i++) begin enc_a = ~enc_a; settle(); end
    chk("R7 A edges up", int'(count_o), 103);
    for (int i = 0; i < 2; i++) begin enc_b = ~enc_b; settle(); end
    chk("R7 B edges ignored", int'(count_o), 103);
    enc_b = 1'b1; settle();
    for (int i = 0; i < 2; i++) begin enc_a = ~enc_a; settle(); end
    chk("R7 A edges down", int'(count_o), 101);
    rd(2'd2, v); chk("R11 dir shows down", (v >> 4) & 1, 1);
  endtask

  task automatic t_mode_b();
    wr(2'd3, 2);
    enc_a = 1'b0; settle();
    wr(2'd0, 100);
    for (int i = 0; i < 2; i++) begin enc_b = ~enc_b; settle(); end
    chk("R8 B edges up", int'(count_o), 102);
    enc_a = 1'b1; settle();
    chk("R8 A edge ignored", int'(count_o), 102);
    enc_b = ~enc_b; settle();
    chk("R8 B edge down", int'(count_o), 101);
  endtask

  task automatic t_quad();
    wr(2'd3, 0);
    enc_a = 1'b0; enc_b = 1'b0; settle();
    wr(2'd3, 3);
    wr(2'd0, 100);
    enc_a = 1; settle(); enc_b = 1; settle();
    enc_a = 0; settle(); enc_b = 0; settle();
    chk("R9 forward cycle", int'(count_o), 104);
    enc_b = 1; settle(); enc_a = 1; settle();
    enc_b = 0; settle(); enc_a = 0; settle();
    chk("R9 reverse cycle", int'(count_o), 100);
    chk("R10 no error yet", int'(qerr_o), 0);
  endtask

  task automatic t_quad_err();
    enc_a = 1; enc_b = 1; settle();
    chk("R10 invalid no step", int'(count_o), 100);
    chk("R10 error set", int'(qerr_o), 1);
    enc_a = 0; settle();
    chk("R9 valid after error", int'(count_o), 101);
    chk("R10 error sticky", int'(qerr_o), 1);
    wr(2'd2, 'h181);
    chk("R10 error cleared", int'(qerr_o), 0);
  endtask

  task automatic t_trig();
    wr(2'd3, 4);
    wr(2'd2, 'h81);
    repeat (3) @(negedge clk);
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
    chk("R12 reload up to zero", int'(count_o), 0);
    @(negedge clk); chk("R3 counting after reload", int'(count_o), 1);
    wr(2'd2, 'h91);
    repeat (2) @(negedge clk);
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
    chk("R12 reload down to preset", int'(count_o), 1000);
    @(negedge clk); chk("R12 down after reload", int'(count_o), 999);
    @(negedge clk);
    trig_in = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd42;
    @(negedge clk);
    trig_in = 1'b0; wr_en = 1'b0;
    chk("R12 host write wins", int'(count_o), 42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clk_up();
    t_clk_down();
    t_preload();
    t_enable();
    t_mode_a();
    t_mode_b();
    t_quad();
    t_quad_err();
    t_trig();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule